// File: doc/BRIEF.md
# Calibrated ADC Code Scaler

This block turns a raw 10-bit converter code, tagged with a channel number, into a signed physical quantity: millivolts for voltage and temperature-sense channels and milliamps for current channels. The channel number selects a nominal input range. For four channel groups it also selects a factory calibration. When a group holds a calibration, the code passes through a two-point line instead of the nominal range. Calibration is given to the block as a high and a low reference code per group. On load, the block derives a gain and an offset once and keeps them until the next load or reset.

All work shares one iterative restoring divider. Every job, whether conversion or calibration, holds the block busy for the same fixed number of cycles. While it is busy the block accepts nothing. The battery-current group works on a binary scale of 2^20 and ends with an arithmetic right shift. The other calibrated groups work on a decimal scale of 1000 and end with a division that truncates toward zero.

Top module: `scaler`

## Requirements
- R1: With no calibration in effect, the result is base + floor(span × code / 1024). Per channel number (hex), base/span is: 03 and 09 → 0/20030; 01, 02, 04, 06, 07, 12 → 0/1350; 08 and 13 → 2300/2500; 0A and 0B → 0/1500; 0C → 0/3200; 05 → 0/2500; 0D → 0/1350; FF → −6000/12000.
- R2: Calibration groups are selected by cal_group: 0 = channel 03; 1 = channels 01, 02, 04, 06, 07, 12; 2 = channels 08, 13; 3 = channel FF. A group counts as calibrated when its stored gain is nonzero.
- R3: For groups 0 to 2, a load sets gain = trunc(1000 × (Href − Lref) / (hi − lo)) and offset = 1000 × Href − gain × hi. A conversion then returns trunc((code × gain + offset) / 1000). Truncation is toward zero, including for negative values and for a negative hi − lo.
- R4: The reference pairs (Lref, Href) are (315, 19500) for group 0, (21, 1300) for group 1 and (2380, 4700) for group 2.
- R5: For group 3, q = trunc((112 × 2^20) / (hi − lo)), gain = 100 × q and offset = 100 × (56 × 2^20 − q × hi). A conversion returns floor((code × gain + offset) / 2^20), which is an arithmetic shift.
- R6: Channels 05, 09, 0A, 0B, 0C and 0D always use their nominal range, whatever calibration has been loaded.
- R7: Any channel number not listed in R1 gives out_err = 1 and out_value = 0 with out_valid. Listed channels give out_err = 0.
- R8: out_valid is a one-cycle pulse that rises exactly NUMW+1 clock edges after the edge that accepted the conversion (41 by default).
- R9: in_ready is low from the accepting edge until the job finishes. Any in_valid or cal_load seen while in_ready is low is dropped. When in_valid and cal_load are both high in an accepting cycle, the conversion is taken and the calibration is dropped.
- R10: A calibration load with hi equal to lo stores a zero gain, so the group returns to its nominal range.
- R11: An accepted calibration load keeps in_ready low for NUMW+1 edges and produces no out_valid.
- R12: After reset, in_ready = 1, out_valid = 0 and every group is uncalibrated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion request |
| in_ready | output | 1 | High when a request or calibration load is accepted |
| in_chan | input | 8 | Channel number |
| in_code | input | CODEW | Raw converter code |
| cal_load | input | 1 | Calibration load request |
| cal_group | input | 2 | Calibration group being loaded |
| cal_hi | input | CODEW | High reference code |
| cal_lo | input | CODEW | Low reference code |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Unknown channel flag, qualified by out_valid |
| out_value | output | OUTW | Signed result in mV or mA |

## Verification
The bench aims at rounding direction. On the decimal path a code below the low reference gives a small negative numerator, and a floor in place of truncation would return −57 where −56 is right. On the current path the opposite holds: a truncating design would return −5599 instead of −5600. A reversed reference pair (hi below lo) checks that a negative divisor is handled through its sign, not treated as a large unsigned value. Requests presented while busy, and a calibration arriving in the same cycle as a conversion, are applied and then followed by an uncalibrated read. A design that took either one would show the calibrated value −56 in place of the nominal 19. An equal hi/lo load must fall back to the nominal range rather than produce the divider's all-ones quotient.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

   localparam longint DEC_SCALE = 1000;
   localparam int     CUR_FRAC  = 20;
   localparam longint DROP_HI   = 56;
   localparam longint DROP_LO   = -56;
   localparam longint SNS_HI    = 60;
   localparam longint SNS_LO    = -60;
   localparam longint CUR_HI    = 6000;
   localparam longint CUR_LO    = -6000;
   // sense-voltage to current mapping
   localparam longint V2A_GAIN  = (CUR_HI - CUR_LO) / (SNS_HI - SNS_LO);
   localparam longint V2A_OFF   = ((SNS_HI * CUR_LO - CUR_HI * SNS_LO) <<< CUR_FRAC)
                                  / (SNS_HI - SNS_LO);

   typedef enum logic [1:0] {
      GRP_VMAIN = 2'd0,
      GRP_TEMP  = 2'd1,
      GRP_VBAT  = 2'd2,
      GRP_IBAT  = 2'd3
   } cal_grp_e;

   typedef enum logic [1:0] {
      JOB_LINEAR,
      JOB_DECIMAL,
      JOB_SHIFT,
      JOB_FAULT
   } job_e;

   typedef struct packed {
      logic               known;
      logic               has_grp;
      cal_grp_e           grp;
      logic signed [31:0] base;
      logic [31:0]        span;
   } chan_info_t;

   function automatic longint ref_hi(input cal_grp_e g);
      case (g)
         GRP_VMAIN: return 19500;
         GRP_TEMP:  return 1300;
         GRP_VBAT:  return 4700;
         default:   return 0;
      endcase
   endfunction

   function automatic longint ref_lo(input cal_grp_e g);
      case (g)
         GRP_VMAIN: return 315;
         GRP_TEMP:  return 21;
         GRP_VBAT:  return 2380;
         default:   return 0;
      endcase
   endfunction

   function automatic longint cal_numer(input cal_grp_e g);
      if (g == GRP_IBAT) return (DROP_HI - DROP_LO) <<< CUR_FRAC;
      return DEC_SCALE * (ref_hi(g) - ref_lo(g));
   endfunction

   function automatic logic [63:0] mag64(input logic signed [63:0] v);
      return (v < 0) ? $unsigned(-v) : $unsigned(v);
   endfunction

endpackage

// File: rtl/scaler_chan_decode.sv
module scaler_chan_decode
   import scaler_pkg::*;
(
   input  logic [7:0] chan,
   output chan_info_t info
);
   always_comb begin
      info         = '0;
      info.known   = 1'b1;
      info.has_grp = 1'b0;
      info.grp     = GRP_VMAIN;
      case (chan)
         8'h03: begin info.has_grp = 1'b1; info.grp = GRP_VMAIN; info.span = 32'd20030; end
         8'h01, 8'h02, 8'h04, 8'h06, 8'h07, 8'h12: begin
            info.has_grp = 1'b1; info.grp = GRP_TEMP; info.span = 32'd1350;
         end
         8'h08, 8'h13: begin
            info.has_grp = 1'b1; info.grp = GRP_VBAT;
            info.base = 32'sd2300; info.span = 32'd2500;
         end
         8'hFF: begin
            info.has_grp = 1'b1; info.grp = GRP_IBAT;
            info.base = -32'sd6000; info.span = 32'd12000;
         end
         8'h09:        info.span = 32'd20030;
         8'h0A, 8'h0B: info.span = 32'd1500;
         8'h0C:        info.span = 32'd3200;
         8'h05:        info.span = 32'd2500;
         8'h0D:        info.span = 32'd1350;
         default:      info.known = 1'b0;
      endcase
   end
endmodule

// File: rtl/scaler_divider.sv
module scaler_divider #(
   parameter int NUMW = 40,
   parameter int DENW = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NUMW-1:0] num,
   input  logic [DENW-1:0] den,
   output logic            done,
   output logic [NUMW-1:0] quo
);
   localparam int CW = $clog2(NUMW + 1);

   logic [NUMW-1:0] q_r;
   logic [DENW:0]   rem_r;
   logic [DENW-1:0] den_r;
   logic [CW-1:0]   cnt_r;
   logic            act_r;
   logic [DENW:0]   rem_sh;
   logic [DENW+1:0] diff;

   assign rem_sh = {rem_r[DENW-1:0], q_r[NUMW-1]};
   assign diff   = {1'b0, rem_sh} - {2'b00, den_r};
   assign done   = act_r && (cnt_r == CW'(NUMW));
   assign quo    = q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         rem_r <= '0;
         den_r <= '0;
         cnt_r <= '0;
         act_r <= 1'b0;
      end else if (start) begin
         q_r   <= num;
         rem_r <= '0;
         den_r <= den;
         cnt_r <= '0;
         act_r <= 1'b1;
      end else if (act_r) begin
         if (done) begin
            act_r <= 1'b0;
         end else begin
            cnt_r <= cnt_r + 1'b1;
            if (!diff[DENW+1]) begin
               rem_r <= diff[DENW:0];
               q_r   <= {q_r[NUMW-2:0], 1'b1};
            end else begin
               rem_r <= rem_sh;
               q_r   <= {q_r[NUMW-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/scaler_cal_bank.sv
module scaler_cal_bank #(
   parameter int GW   = 64,
   parameter int NGRP = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [$clog2(NGRP)-1:0] wr_sel,
   input  logic signed [GW-1:0] wr_gain,
   input  logic signed [GW-1:0] wr_off,
   input  logic [$clog2(NGRP)-1:0] rd_sel,
   output logic signed [GW-1:0] rd_gain,
   output logic signed [GW-1:0] rd_off
);
   localparam int SW = $clog2(NGRP);

   logic signed [GW-1:0] gain_q [NGRP];
   logic signed [GW-1:0] off_q  [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gain_q[g] <= '0;
            off_q[g]  <= '0;
         end else if (wr_en && wr_sel == SW'(g)) begin
            gain_q[g] <= wr_gain;
            off_q[g]  <= wr_off;
         end
      end
   end

   assign rd_gain = gain_q[rd_sel];
   assign rd_off  = off_q[rd_sel];
endmodule

// File: rtl/scaler.sv
module scaler
   import scaler_pkg::*;
#(
   parameter int CODEW = 10,
   parameter int OUTW  = 32,
   parameter int NUMW  = 40
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [7:0]             in_chan,
   input  logic [CODEW-1:0]       in_code,
   input  logic                   cal_load,
   input  logic [1:0]             cal_group,
   input  logic [CODEW-1:0]       cal_hi,
   input  logic [CODEW-1:0]       cal_lo,
   output logic                   out_valid,
   output logic                   out_err,
   output logic signed [OUTW-1:0] out_value
);
   localparam int AW   = 64;
   localparam int DENW = CODEW + 1;
   localparam int LAT  = NUMW + 1;

   chan_info_t info;
   scaler_chan_decode u_dec (.chan(in_chan), .info(info));

   logic signed [AW-1:0] rd_gain, rd_off, wr_gain, wr_off;
   logic                 wr_en;
   cal_grp_e             job_grp_q;

   scaler_cal_bank #(.GW(AW), .NGRP(4)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(job_grp_q),
      .wr_gain(wr_gain), .wr_off(wr_off), .rd_sel(info.grp),
      .rd_gain(rd_gain), .rd_off(rd_off)
   );

   logic busy_q;
   logic acc_conv, acc_cal, start;
   assign in_ready = !busy_q;
   assign acc_conv = in_valid && !busy_q;
   assign acc_cal  = cal_load && !busy_q && !in_valid;
   assign start    = acc_conv || acc_cal;

   // accept-side arithmetic
   logic signed [AW-1:0] code_s, prod_s, hi_s, lo_s, cspan_s;
   logic [AW-1:0]        lin_num;
   job_e                 mode_d;
   logic [NUMW-1:0]      num_d;
   logic [DENW-1:0]      den_d;
   logic                 neg_d;

   assign code_s  = $signed({{(AW-CODEW){1'b0}}, in_code});
   assign hi_s    = $signed({{(AW-CODEW){1'b0}}, cal_hi});
   assign lo_s    = $signed({{(AW-CODEW){1'b0}}, cal_lo});
   assign cspan_s = hi_s - lo_s;
   assign prod_s  = code_s * rd_gain + rd_off;
   assign lin_num = {{(AW-32){1'b0}}, info.span} * {{(AW-CODEW){1'b0}}, in_code};

   always_comb begin
      if (!info.known)                           mode_d = JOB_FAULT;
      else if (!info.has_grp || rd_gain == '0)   mode_d = JOB_LINEAR;
      else if (info.grp == GRP_IBAT)             mode_d = JOB_SHIFT;
      else                                       mode_d = JOB_DECIMAL;

      num_d = '0;
      den_d = DENW'(1);
      neg_d = 1'b0;
      if (acc_cal) begin
         num_d = NUMW'(cal_numer(cal_grp_e'(cal_group)));
         den_d = DENW'(mag64(cspan_s));
         neg_d = cspan_s < 0;
      end else if (mode_d == JOB_LINEAR) begin
         num_d = NUMW'(lin_num);
         den_d = DENW'(2 ** CODEW);
      end else if (mode_d == JOB_DECIMAL) begin
         num_d = NUMW'(mag64(prod_s));
         den_d = DENW'(DEC_SCALE);
         neg_d = prod_s < 0;
      end
   end

   logic            div_done;
   logic [NUMW-1:0] div_quo;
   scaler_divider #(.NUMW(NUMW), .DENW(DENW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(start), .num(num_d), .den(den_d),
      .done(div_done), .quo(div_quo)
   );

   // job context held across the division
   logic                 job_cal_q, job_neg_q, job_zero_q;
   job_e                 job_mode_q;
   logic signed [31:0]   job_base_q;
   logic signed [AW-1:0] job_shift_q, job_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         job_cal_q   <= 1'b0;
         job_neg_q   <= 1'b0;
         job_zero_q  <= 1'b0;
         job_mode_q  <= JOB_LINEAR;
         job_base_q  <= '0;
         job_shift_q <= '0;
         job_hi_q    <= '0;
         job_grp_q   <= GRP_VMAIN;
      end else if (start) begin
         job_cal_q   <= acc_cal;
         job_neg_q   <= neg_d;
         job_zero_q  <= cspan_s == '0;
         job_mode_q  <= mode_d;
         job_base_q  <= info.base;
         job_shift_q <= prod_s >>> CUR_FRAC;
         job_hi_q    <= hi_s;
         job_grp_q   <= cal_grp_e'(cal_group);
      end
   end

   // finish-side arithmetic
   logic signed [AW-1:0] q_s, res_s;
   always_comb begin
      q_s = $signed({{(AW-NUMW){1'b0}}, div_quo});
      if (job_neg_q) q_s = -q_s;

      wr_en   = div_done && job_cal_q;
      wr_gain = '0;
      wr_off  = '0;
      if (!job_zero_q) begin
         if (job_grp_q == GRP_IBAT) begin
            wr_gain = V2A_GAIN * q_s;
            wr_off  = V2A_GAIN * ((DROP_HI <<< CUR_FRAC) - q_s * job_hi_q) + V2A_OFF;
         end else begin
            wr_gain = q_s;
            wr_off  = DEC_SCALE * ref_hi(job_grp_q) - q_s * job_hi_q;
         end
      end

      case (job_mode_q)
         JOB_LINEAR:  res_s = {{(AW-32){job_base_q[31]}}, job_base_q} + q_s;
         JOB_DECIMAL: res_s = q_s;
         JOB_SHIFT:   res_s = job_shift_q;
         default:     res_s = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_value <= '0;
      end else begin
         out_valid <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
         end else if (div_done) begin
            busy_q <= 1'b0;
            if (!job_cal_q) begin
               out_valid <= 1'b1;
               out_err   <= job_mode_q == JOB_FAULT;
               out_value <= OUTW'(res_s);
            end
         end
      end
   end
endmodule

// File: rtl/scaler_chk.sv
module scaler_chk #(
   parameter int OUTW    = 32,
   parameter int LAT_CYC = 41
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   cal_load,
   input logic                   out_valid,
   input logic                   out_err,
   input logic signed [OUTW-1:0] out_value
);
   logic [15:0] since_q;
   logic        pend_conv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q     <= '0;
         pend_conv_q <= 1'b0;
      end else if (in_ready && in_valid) begin
         since_q     <= '0;
         pend_conv_q <= 1'b1;
      end else if (in_ready && cal_load) begin
         since_q     <= '0;
         pend_conv_q <= 1'b0;
      end else if (!in_ready) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R8
   lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pend_conv_q && since_q == 16'(LAT_CYC)));

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R9
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && (in_valid || cal_load)) |=> !in_ready);

   // R7
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_value == '0));

   // R11
   cal_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_conv_q |-> !out_valid);
endmodule

bind scaler scaler_chk #(.OUTW(OUTW), .LAT_CYC(LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .cal_load(cal_load), .out_valid(out_valid), .out_err(out_err),
   .out_value(out_value)
);

// File: tb/scaler_tb.sv
`timescale 1ns/1ps
module scaler_tb;
   localparam int LAT = 41;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic               in_valid = 1'b0, cal_load = 1'b0;
   logic [7:0]         in_chan = '0;
   logic [9:0]         in_code = '0, cal_hi = '0, cal_lo = '0;
   logic [1:0]         cal_group = '0;
   logic               in_ready, out_valid, out_err;
   logic signed [31:0] out_value;

   scaler u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_chan(in_chan), .in_code(in_code), .cal_load(cal_load),
      .cal_group(cal_group), .cal_hi(cal_hi), .cal_lo(cal_lo),
      .out_valid(out_valid), .out_err(out_err), .out_value(out_value)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_ready();
      int n = 0;
      while (!in_ready && n < 300) begin @(posedge clk); @(negedge clk); n++; end
   endtask

   task automatic conv(input logic [7:0] ch, input logic [9:0] cd,
                       output longint v, output logic e, output int lat);
      @(negedge clk);
      wait_ready();
      in_valid = 1'b1; in_chan = ch; in_code = cd;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      lat = 0;
      while (!out_valid && lat < 200) begin @(posedge clk); lat++; @(negedge clk); end
      v = out_value;
      e = out_err;
   endtask

   task automatic conv_chk(input string req, input logic [7:0] ch, input logic [9:0] cd,
                           input longint ev, input logic ee);
      longint v; logic e; int lat;
      conv(ch, cd, v, e, lat);
      chk(req, "value", v, ev);
      chk(req, "error flag", e, ee);
      chk("R8", "latency", lat, LAT);
   endtask

   task automatic load_cal(input logic [1:0] g, input logic [9:0] hi, input logic [9:0] lo);
      int busy = 0; int seen = 0;
      @(negedge clk);
      wait_ready();
      cal_load = 1'b1; cal_group = g; cal_hi = hi; cal_lo = lo;
      @(posedge clk); @(negedge clk);
      cal_load = 1'b0;
      while (!in_ready && busy < 200) begin
         if (out_valid) seen++;
         @(posedge clk); busy++; @(negedge clk);
      end
      if (out_valid) seen++;
      chk("R11", "calibration busy cycles", busy, LAT);
      chk("R11", "strobes during calibration", seen, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R12", "in_ready after reset", in_ready, 1);
      chk("R12", "out_valid after reset", out_valid, 0);
      conv_chk("R12", 8'h03, 10'd1, 19, 1'b0);
   endtask

   task automatic t_nominal();
      conv_chk("R1", 8'h09, 10'd512, 10015, 1'b0);
      conv_chk("R1", 8'h08, 10'd1023, 4797, 1'b0);
      conv_chk("R1", 8'hFF, 10'd0, -6000, 1'b0);
      conv_chk("R1", 8'hFF, 10'd1023, 5988, 1'b0);
      conv_chk("R1", 8'h0A, 10'd300, 439, 1'b0);
      conv_chk("R1", 8'h0C, 10'd1000, 3125, 1'b0);
      conv_chk("R1", 8'h05, 10'd100, 244, 1'b0);
      conv_chk("R1", 8'h0D, 10'd777, 1024, 1'b0);
   endtask

   task automatic t_unknown();
      conv_chk("R7", 8'h0E, 10'd500, 0, 1'b1);
      conv_chk("R7", 8'h1C, 10'd5, 0, 1'b1);
   endtask

   task automatic t_busy_drop();
      longint v = 0; int nv = 0;
      @(negedge clk);
      wait_ready();
      in_valid = 1'b1; in_chan = 8'h09; in_code = 10'd512;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R9", "in_ready while busy", in_ready, 0);
      in_valid = 1'b1; in_chan = 8'h0C; in_code = 10'd1000;
      cal_load = 1'b1; cal_group = 2'd0; cal_hi = 10'd1000; cal_lo = 10'd20;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; cal_load = 1'b0;
      for (int i = 0; i < LAT + 10; i++) begin
         if (out_valid) begin nv++; if (nv == 1) v = out_value; end
         @(posedge clk); @(negedge clk);
      end
      chk("R9", "strobe count", nv, 1);
      chk("R9", "first result kept", v, 10015);
      conv_chk("R9", 8'h03, 10'd1, 19, 1'b0);
   endtask

   task automatic t_same_cycle();
      int n = 0;
      @(negedge clk);
      wait_ready();
      in_valid = 1'b1; in_chan = 8'h09; in_code = 10'd0;
      cal_load = 1'b1; cal_group = 2'd0; cal_hi = 10'd1000; cal_lo = 10'd20;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; cal_load = 1'b0;
      while (!out_valid && n < 200) begin @(posedge clk); n++; @(negedge clk); end
      chk("R9", "conversion wins same cycle", out_value, 0);
      conv_chk("R9", 8'h03, 10'd1, 19, 1'b0);
   endtask

   task automatic t_cal_main();
      load_cal(2'd0, 10'd1000, 10'd20);
      conv_chk("R3", 8'h03, 10'd1000, 19500, 1'b0);
      conv_chk("R4", 8'h03, 10'd20, 315, 1'b0);
      conv_chk("R3", 8'h03, 10'd0, -76, 1'b0);
      conv_chk("R3", 8'h03, 10'd1, -56, 1'b0);
   endtask

   task automatic t_cal_temp();
      load_cal(2'd1, 10'd900, 10'd30);
      conv_chk("R2", 8'h12, 10'd500, 712, 1'b0);
      conv_chk("R4", 8'h02, 10'd900, 1300, 1'b0);
   endtask

   task automatic t_cal_vbat();
      load_cal(2'd2, 10'd800, 10'd100);
      conv_chk("R4", 8'h08, 10'd400, 3374, 1'b0);
      load_cal(2'd2, 10'd100, 10'd800);
      conv_chk("R3", 8'h13, 10'd400, 3705, 1'b0);
   endtask

   task automatic t_cal_current();
      load_cal(2'd3, 10'd600, 10'd40);
      conv_chk("R5", 8'hFF, 10'd600, 5600, 1'b0);
      conv_chk("R5", 8'hFF, 10'd40, -5600, 1'b0);
   endtask

   task automatic t_never_cal();
      conv_chk("R6", 8'h09, 10'd512, 10015, 1'b0);
      conv_chk("R6", 8'h0D, 10'd777, 1024, 1'b0);
      conv_chk("R6", 8'h0B, 10'd300, 439, 1'b0);
   endtask

   task automatic t_zero_span();
      load_cal(2'd0, 10'd500, 10'd500);
      conv_chk("R10", 8'h03, 10'd512, 10015, 1'b0);
      conv_chk("R10", 8'h03, 10'd1, 19, 1'b0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_nominal();
      t_unknown();
      t_busy_drop();
      t_same_cycle();
      t_cal_main();
      t_cal_temp();
      t_cal_vbat();
      t_cal_current();
      t_never_cal();
      t_zero_span();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule